// File: doc/BRIEF.md
# Converter Reset and Start-up Sequencer

This block governs power-down and start-up for a pair of audio converter paths, one ADC and one DAC. A software run bit (1 = run, 0 = hold in reset) comes from a configuration register. A frame tick marks each sample period: it is a single-cycle pulse in the system clock domain. Every delay the block produces is counted in frame ticks, never in system clocks. Without a tick, the sequencer holds its state.

A change of the run bit acts one sample period late, in both directions. When reset is released, the ADC path runs a calibration wait before its data is valid. The length of this wait is set by a two-bit speed code. The code is sampled once, when the wait begins. During power-down and during the wait, the serial ADC data is forced to zero. The DAC digital path resumes as soon as the internal reset drops. The configuration registers are not touched by the software reset, and they stay outside this block.

Top module: `conv_rst_seq`

## Requirements
- R1: A run bit of 0 that is sampled by one frame tick takes effect on the next frame tick. At that tick the sequencer enters power-down from either the waiting state or the running state.
- R2: After release, a run bit of 1 sampled by one frame tick starts the calibration wait on the next frame tick. Before that second tick, intRst stays 1.
- R3: With speed code 2'b00, the wait covers exactly 5200 frame ticks. initBusy is still 1 after the 5199th tick that follows entry, and is 0 after the 5200th.
- R4: With speed code 2'b01, the wait covers exactly 10000 frame ticks.
- R5: With speed code 2'b10, the wait covers exactly 19200 frame ticks.
- R6: Speed code 2'b11 gives a 19200-tick wait. It also sets modeErr when the wait starts. modeErr stays set until the hardware reset rstN.
- R7: In power-down, intRst, adcAnaPd, adcDigPd and dacDigPd are all 1. In any other state they are all 0.
- R8: adcZero is 1 in power-down and during the wait. It is 0 only once the wait has completed.
- R9: dacDigPd is 0 throughout the calibration wait.
- R10: A run bit of 0 that arrives during the wait aborts it, with the same one-tick delay as R1. This holds even when the abort lands on the tick that would have ended the wait. In that case power-down wins.
- R11: A change of speed code after the wait has started does not change the length of that wait.
- R12: Without frame ticks, a change of the run bit has no effect on any output.
- R13: The hardware reset rstN (active low) puts the block in power-down with modeErr at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| frameTick | input | 1 | One-cycle pulse per sample period |
| swRun | input | 1 | Software run bit: 1 run, 0 hold in reset |
| speedMode | input | 2 | Speed code: 00 normal, 01 double, 10 quad, 11 reserved |
| intRst | output | 1 | Internal reset, active high |
| adcAnaPd | output | 1 | ADC analog power-down |
| adcDigPd | output | 1 | ADC digital power-down |
| dacDigPd | output | 1 | DAC digital power-down |
| initBusy | output | 1 | Calibration wait in progress |
| adcZero | output | 1 | Force serial ADC data to zero |
| modeErr | output | 1 | Sticky flag: reserved speed code was used |

## Verification
Two functions can fall on the same frame tick: an abort request, and the completion of the calibration wait. To provoke this, the bench releases reset in double-speed mode. It then lets the wait run until two ticks remain, and clears the run bit. The bit is sampled on the second-to-last tick, so the abort acts on exactly the tick where the counter would finish. The bench then checks that the block lands in power-down, with intRst high, initBusy low and adcZero still high, and never passes through the running state.

// File: rtl/convrst_pkg.sv
package convrst_pkg;
  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/convrst_cnt.sv
module convrst_cnt
  import convrst_pkg::*;
#(
  parameter int NORM_LEN = 5200,
  parameter int DBL_LEN  = 10000,
  parameter int QUAD_LEN = 19200
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  input  logic [1:0] speedMode,
  output logic       lastTick,
  output logic       modeReserved
);
  localparam int CW = $clog2(QUAD_LEN + 1);

  logic [CW-1:0] count;
  logic [CW-1:0] lenSel;

  always_comb begin
    unique case (speedMode)
      2'b00:   lenSel = CW'(NORM_LEN);
      2'b01:   lenSel = CW'(DBL_LEN);
      default: lenSel = CW'(QUAD_LEN);
    endcase
  end

  assign modeReserved = (speedMode == 2'b11);
  assign lastTick     = (count == CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.load) count <= lenSel;
    else if (strobe.dec)  count <= count - CW'(1);
  end

  // R12 / R11: the count only moves on a strobe from the controller
  p_hold_count_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.dec) |=> $stable(count));

  // R3: a load with the normal code yields the normal length
  p_load_norm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && speedMode == 2'b00) |=> count == CW'(NORM_LEN));

  // R6: the reserved code falls back to the quad length
  p_load_resv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && speedMode == 2'b11) |=> count == CW'(QUAD_LEN));
endmodule

// File: rtl/convrst_ctrl.sv
module convrst_ctrl
  import convrst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       swRun,
  input  logic       lastTick,
  input  logic       modeReserved,
  output cntStrobe_t strobe,
  output logic       intRst,
  output logic       adcAnaPd,
  output logic       adcDigPd,
  output logic       dacDigPd,
  output logic       initBusy,
  output logic       adcZero,
  output logic       modeErr
);
  seqState_t state;
  logic      pendRun;

  always_comb begin
    strobe.load = frameTick && (state == ST_DOWN) && pendRun;
    strobe.dec  = frameTick && (state == ST_INIT) && pendRun && !lastTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_DOWN;
      pendRun <= 1'b0;
      modeErr <= 1'b0;
    end else if (frameTick) begin
      pendRun <= swRun;
      unique case (state)
        ST_DOWN: if (pendRun) state <= ST_INIT;
        ST_INIT: begin
          if (!pendRun)     state <= ST_DOWN;
          else if (lastTick) state <= ST_RUN;
        end
        ST_RUN:  if (!pendRun) state <= ST_DOWN;
        default: state <= ST_DOWN;
      endcase
      if (strobe.load && modeReserved) modeErr <= 1'b1;
    end
  end

  always_comb begin
    intRst   = (state == ST_DOWN);
    adcAnaPd = intRst;
    adcDigPd = intRst;
    dacDigPd = intRst;
    initBusy = (state == ST_INIT);
    adcZero  = (state != ST_RUN);
  end

  // R1 / R10: a sampled reset request forces power-down on the next tick
  p_req_delay_r1: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && !pendRun && state != ST_DOWN) |=> state == ST_DOWN);

  // R12: no tick, no state change
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(state));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);

  // R3: wait ends into run when the counter reports its final tick
  p_finish_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT && frameTick && pendRun && lastTick) |=> state == ST_RUN);

  // R2: a release enters the wait, never run directly
  p_no_skip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DOWN) |=> state != ST_RUN);
endmodule

// File: rtl/conv_rst_seq.sv
module conv_rst_seq
  import convrst_pkg::*;
#(
  parameter int NORM_LEN = 5200,
  parameter int DBL_LEN  = 10000,
  parameter int QUAD_LEN = 19200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameTick,
  input  logic       swRun,
  input  logic [1:0] speedMode,
  output logic       intRst,
  output logic       adcAnaPd,
  output logic       adcDigPd,
  output logic       dacDigPd,
  output logic       initBusy,
  output logic       adcZero,
  output logic       modeErr
);
  cntStrobe_t strobe;
  logic       lastTick;
  logic       modeReserved;

  convrst_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameTick    (frameTick),
    .swRun        (swRun),
    .lastTick     (lastTick),
    .modeReserved (modeReserved),
    .strobe       (strobe),
    .intRst       (intRst),
    .adcAnaPd     (adcAnaPd),
    .adcDigPd     (adcDigPd),
    .dacDigPd     (dacDigPd),
    .initBusy     (initBusy),
    .adcZero      (adcZero),
    .modeErr      (modeErr)
  );

  convrst_cnt #(
    .NORM_LEN (NORM_LEN),
    .DBL_LEN  (DBL_LEN),
    .QUAD_LEN (QUAD_LEN)
  ) u_cnt (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .speedMode    (speedMode),
    .lastTick     (lastTick),
    .modeReserved (modeReserved)
  );

  // R9: the DAC digital path is never held while the wait runs
  p_dac_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    initBusy |-> !dacDigPd);

  // R8: ADC data cannot be released while the wait is still busy
  p_zero_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    initBusy |-> adcZero);
endmodule

// File: tb/sim_conv_rst_seq.sv
module sim_conv_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;
  localparam int LEN_N = 5200;
  localparam int LEN_D = 10000;
  localparam int LEN_Q = 19200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b0;
  logic swRun = 1'b0;
  logic [1:0] speedMode = 2'b00;
  logic intRst, adcAnaPd, adcDigPd, dacDigPd, initBusy, adcZero, modeErr;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_rst_seq u0 (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .swRun(swRun),
    .speedMode(speedMode), .intRst(intRst), .adcAnaPd(adcAnaPd),
    .adcDigPd(adcDigPd), .dacDigPd(dacDigPd), .initBusy(initBusy),
    .adcZero(adcZero), .modeErr(modeErr)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) frameTick = 1'b1;
    @(negedge clk) frameTick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic checkPd(string req, logic exp);
    check(req, "intRst", intRst, exp);
    check(req, "adcAnaPd", adcAnaPd, exp);
    check(req, "adcDigPd", adcDigPd, exp);
    check(req, "dacDigPd", dacDigPd, exp);
  endtask

  task automatic enterInit(logic [1:0] mode);
    speedMode = mode;
    swRun = 1'b1;
    ticks(2);
  endtask

  task automatic runWait(int len, string req);
    ticks(len - 1);
    check(req, "initBusy before last tick", initBusy, 1);
    check(req, "adcZero before last tick", adcZero, 1);
    tick1();
    check(req, "initBusy after last tick", initBusy, 0);
    check(req, "adcZero after last tick", adcZero, 0);
  endtask

  task automatic goDown();
    swRun = 1'b0;
    tick1();
    check("R1", "intRst one tick after request", intRst, 0);
    check("R1", "adcZero one tick after request", adcZero, 0);
    tick1();
    checkPd("R7", 1'b1);
    check("R8", "adcZero in power-down", adcZero, 1);
  endtask

  task automatic testResetState();
    checkPd("R13", 1'b1);
    check("R13", "modeErr", modeErr, 0);
    check("R13", "initBusy", initBusy, 0);
  endtask

  task automatic testNormal();
    speedMode = 2'b00;
    swRun = 1'b1;
    repeat (10) @(negedge clk);
    check("R12", "intRst without ticks", intRst, 1);
    tick1();
    check("R2", "intRst after sampling tick", intRst, 1);
    tick1();
    check("R2", "initBusy at start", initBusy, 1);
    checkPd("R7", 1'b0);
    check("R9", "dacDigPd during wait", dacDigPd, 0);
    check("R8", "adcZero during wait", adcZero, 1);
    speedMode = 2'b10;  // R11: late change must not stretch the wait
    runWait(LEN_N, "R3");
    check("R11", "runs after normal length", adcZero, 0);
    goDown();
  endtask

  task automatic testAbortAtEnd();
    enterInit(2'b01);
    ticks(LEN_D - 2);
    swRun = 1'b0;
    tick1();
    check("R10", "still busy after request", initBusy, 1);
    tick1();
    check("R10", "intRst after abort", intRst, 1);
    check("R10", "initBusy after abort", initBusy, 0);
    check("R10", "adcZero after abort", adcZero, 1);
  endtask

  task automatic testDouble();
    enterInit(2'b01);
    runWait(LEN_D, "R4");
    goDown();
  endtask

  task automatic testQuad();
    enterInit(2'b10);
    check("R6", "modeErr with legal code", modeErr, 0);
    runWait(LEN_Q, "R5");
    goDown();
  endtask

  task automatic testReserved();
    enterInit(2'b11);
    check("R6", "modeErr set", modeErr, 1);
    runWait(LEN_Q, "R6");
    goDown();
    check("R6", "modeErr sticky", modeErr, 1);
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    check("R13", "modeErr after hw reset", modeErr, 0);
    check("R13", "intRst after hw reset", intRst, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testNormal();
    testAbortAtEnd();
    testDouble();
    testQuad();
    testReserved();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule